// File: doc/BRIEF.md
# Machine-Mode External IRQ Controller

This block keeps the machine-level interrupt state for eight external, level-sensitive IRQ lines in a small 32-bit core. Each line is first synchronised to the core clock. The result is then visible in a pending register. It is masked by a per-line enable and gated by a global enable. The lowest-numbered line that survives is turned into a registered interrupt request to the pipeline, along with the cause value the pipeline records.

Software reaches the state through a small CSR port. A 2-bit select picks the status, enable, pending or cause register, and reads are combinational. The pipeline pulses `trap_ack_i` when it takes the interrupt. This records the cause, saves the global enable and clears it. A return pulse on `mret_i` restores the saved enable.

Top module: `mext_irq_ctrl`

## Requirements
- R1: After reset `irq_req_o` is 0 and the status, enable and cause registers all read as zero.
- R2: Pending bit 24+n follows line n two clock edges after the line changes, whether or not line n is enabled. Pending bits 0..23 read as zero.
- R3: An enable write stores `csr_wdata_i[31:24]` as the enables of lines 0..7. Enable bits 0..23 read as zero and ignore writes.
- R4: `irq_req_o` is registered. It rises on the edge after the global enable is set while at least one line is both pending and enabled.
- R5: While the global enable (status bit 0) is clear, `irq_req_o` is 0 on the following edge, whatever the lines and enables are.
- R6: When several enabled lines are pending, the lowest-numbered one wins. `cause_o` is 0x80000000 plus (16 + n) for winner n.
- R7: On `trap_ack_i`, the cause register takes `cause_o`, status bit 3 takes the old global enable, and the global enable clears. This takes priority over `mret_i` and over CSR writes.
- R8: On `mret_i` without `trap_ack_i`, the global enable takes status bit 3 and status bit 3 is set to 1. This takes priority over a CSR write.
- R9: Only status bits 0 and 3 are writable. All other status bits read as zero.
- R10: The select encoding is 0 = status, 1 = enable, 2 = pending, 3 = cause. Writes to pending are ignored. The cause register is fully writable by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | External IRQ lines, level-sensitive, asynchronous |
| csr_sel_i | input | 2 | CSR select: 0 status, 1 enable, 2 pending, 3 cause |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for the selected register |
| trap_ack_i | input | 1 | Pipeline has taken the interrupt |
| mret_i | input | 1 | Return from the handler, restores the global enable |
| irq_req_o | output | 1 | Registered interrupt request to the pipeline |
| cause_o | output | 32 | Cause value for the current winning line |

## Verification
The properties assume that `trap_ack_i` and `mret_i` are single-cycle pulses. They also assume that the pipeline asserts `trap_ack_i` only while `irq_req_o` is high, so the recorded cause is always a valid IRQ code. The bench keeps to these assumptions: it issues each pulse on its own between falling edges, and it pulses the acknowledge only after it has seen the request. The IRQ lines change only at falling edges. The bench waits the full synchroniser latency before it judges pending bits or requests.

// File: rtl/mext_irq_pkg.sv
package mext_irq_pkg;
  localparam int XLEN       = 32;
  localparam int NIRQ       = 8;
  localparam int IRQ_LSB    = 24;
  localparam int CAUSE_BASE = 16;
  localparam int GIE_BIT    = 0;
  localparam int PIE_BIT    = 3;
  localparam int IDXW       = $clog2(NIRQ);

  typedef enum logic [1:0] {
    CSR_STATUS  = 2'd0,
    CSR_ENABLE  = 2'd1,
    CSR_PENDING = 2'd2,
    CSR_CAUSE   = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/mext_irq_sync.sv
module mext_irq_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mext_irq_prio.sv
module mext_irq_prio #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  // scan from the top so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mext_irq_csr.sv
module mext_irq_csr
  import mext_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  csr_sel_e        sel_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            trap_ack_i,
  input  logic            mret_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [NIRQ-1:0] pend_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            gie_o,
  output logic            pie_o,
  output logic [NIRQ-1:0] en_o
);
  logic            gie_q, pie_q;
  logic [NIRQ-1:0] en_q;
  logic [XLEN-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      pie_q <= 1'b0;
    end else if (trap_ack_i) begin
      pie_q <= gie_q;
      gie_q <= 1'b0;
    end else if (mret_i) begin
      gie_q <= pie_q;
      pie_q <= 1'b1;
    end else if (we_i && sel_i == CSR_STATUS) begin
      gie_q <= wdata_i[GIE_BIT];
      pie_q <= wdata_i[PIE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          en_q <= '0;
    else if (we_i && sel_i == CSR_ENABLE) en_q <= wdata_i[IRQ_LSB +: NIRQ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cause_q <= '0;
    else if (trap_ack_i)                 cause_q <= cause_i;
    else if (we_i && sel_i == CSR_CAUSE) cause_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      CSR_STATUS: begin
        rdata_o[GIE_BIT] = gie_q;
        rdata_o[PIE_BIT] = pie_q;
      end
      CSR_ENABLE:  rdata_o[IRQ_LSB +: NIRQ] = en_q;
      CSR_PENDING: rdata_o[IRQ_LSB +: NIRQ] = pend_i;
      CSR_CAUSE:   rdata_o = cause_q;
      default:     rdata_o = '0;
    endcase
  end

  assign gie_o = gie_q;
  assign pie_o = pie_q;
  assign en_o  = en_q;
endmodule

// File: rtl/mext_irq_ctrl.sv
module mext_irq_ctrl
  import mext_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [1:0]      csr_sel_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            trap_ack_i,
  input  logic            mret_i,
  output logic            irq_req_o,
  output logic [XLEN-1:0] cause_o
);
  logic [NIRQ-1:0] pend_w, en_w, live_w;
  logic            gie_w, pie_w, any_w;
  logic [IDXW-1:0] idx_w, idx_q;
  logic            req_q;

  mext_irq_sync #(.N(NIRQ), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(pend_w)
  );

  assign live_w = pend_w & en_w;

  mext_irq_prio #(.N(NIRQ), .IDXW(IDXW)) u_prio (
    .req_i(live_w), .any_o(any_w), .idx_o(idx_w)
  );

  mext_irq_csr u_csr (
    .clk_i, .rst_ni,
    .sel_i     (csr_sel_e'(csr_sel_i)),
    .we_i      (csr_we_i),
    .wdata_i   (csr_wdata_i),
    .trap_ack_i,
    .mret_i,
    .cause_i   (cause_o),
    .pend_i    (pend_w),
    .rdata_o   (csr_rdata_o),
    .gie_o     (gie_w),
    .pie_o     (pie_w),
    .en_o      (en_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      req_q <= gie_w & any_w;
      idx_q <= idx_w;
    end
  end

  assign irq_req_o = req_q;
  assign cause_o   = {1'b1, {(XLEN-1){1'b0}}} | (XLEN'(CAUSE_BASE) + XLEN'(idx_q));
endmodule

// File: rtl/mext_irq_checker.sv
module mext_irq_checker
  import mext_irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      csr_sel_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            trap_ack_i,
  input logic            mret_i,
  input logic            irq_req_o,
  input logic [XLEN-1:0] cause_o,
  input logic [NIRQ-1:0] pend_w,
  input logic [NIRQ-1:0] en_w,
  input logic            gie_w,
  input logic            pie_w
);
  a_r2_pending_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == CSR_PENDING) |-> csr_rdata_o[IRQ_LSB-1:0] == '0);

  a_r3_enable_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == CSR_ENABLE) |-> csr_rdata_o[IRQ_LSB-1:0] == '0);

  a_r4_req_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_w && |(pend_w & en_w)) |=> irq_req_o);

  a_r5_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_w |=> !irq_req_o);

  a_r6_cause_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:5] == '0 && cause_o[4]));

  a_r7_trap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_ack_i |=> (!gie_w && pie_w == $past(gie_w)));

  a_r8_mret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_ack_i) |=> (gie_w == $past(pie_w) && pie_w));

  a_r9_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == CSR_STATUS) |-> (csr_rdata_o & ~32'h9) == '0);
endmodule

bind mext_irq_ctrl mext_irq_checker u_chk (
  .clk_i, .rst_ni, .csr_sel_i, .csr_rdata_o, .trap_ack_i, .mret_i,
  .irq_req_o, .cause_o, .pend_w, .en_w, .gie_w, .pie_w
);

// File: tb/mext_irq_ctrl_bench.sv
module mext_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0;
  logic [1:0]  sel = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        trap_ack = 1'b0;
  logic        mret = 1'b0;
  logic        req;
  logic [31:0] cause;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mext_irq_ctrl u_mext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .csr_sel_i(sel),
    .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .trap_ack_i(trap_ack), .mret_i(mret), .irq_req_o(req), .cause_o(cause)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic csr_rd(logic [1:0] s, output logic [31:0] d);
    sel = s; #1; d = rdata;
  endtask

  function automatic logic [31:0] exp_cause(logic [7:0] live);
    for (int i = 0; i < 8; i++) if (live[i]) return 32'h8000_0000 + 32'(16 + i);
    return 32'h8000_0010;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", 32'(req), 0);
    csr_rd(2'd0, d); chk("R1 status", d, 0);
    csr_rd(2'd1, d); chk("R1 enable", d, 0);
    csr_rd(2'd3, d); chk("R1 cause", d, 0);

    // R3, R9, R10 register access
    csr_wr(2'd1, 32'hFFFF_FFFF);
    csr_rd(2'd1, d); chk("R3 enable mask", d, 32'hFF00_0000);
    csr_wr(2'd1, 32'h00FF_FFFF);
    csr_rd(2'd1, d); chk("R3 enable low ignored", d, 32'h0);
    csr_wr(2'd0, 32'hFFFF_FFF6);
    csr_rd(2'd0, d); chk("R9 status mask", d, 32'h0);
    csr_wr(2'd0, 32'hFFFF_FFFF);
    csr_rd(2'd0, d); chk("R9 status both", d, 32'h9);
    csr_wr(2'd0, 32'h0);
    csr_wr(2'd3, 32'h1234_5678);
    csr_rd(2'd3, d); chk("R10 cause rw", d, 32'h1234_5678);
    csr_wr(2'd2, 32'hFFFF_FFFF);
    csr_rd(2'd2, d); chk("R10 pending write ignored", d, 32'h0);

    // R5 global enable clear: no request for any pattern
    csr_wr(2'd1, 32'hFF00_0000);
    for (int p = 1; p < 256; p += 17) begin
      @(negedge clk); irq = 8'(p);
      repeat (4) @(negedge clk);
      chk("R5 gated", 32'(req), 0);
    end

    // R2, R4, R6 sweep over every line pattern and several enables
    csr_wr(2'd0, 32'h1);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); irq = 8'(p);
      @(negedge clk);
      @(negedge clk);
      csr_rd(2'd2, d); chk("R2 pending", d, {8'(p), 24'h0});
      for (int k = 0; k < 6; k++) begin
        logic [7:0] e;
        e = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : 8'((p * 37 + k * 91) ^ (k << 4));
        csr_wr(2'd1, {e, 24'h0});
        @(negedge clk);
        chk("R4 req", 32'(req), 32'(|(8'(p) & e)));
        if (|(8'(p) & e)) chk("R6 cause", cause, exp_cause(8'(p) & e));
      end
    end

    // R2 pending drops with the line, while disabled
    csr_wr(2'd1, 32'h0);
    @(negedge clk); irq = 8'h00;
    @(negedge clk);
    csr_rd(2'd2, d); chk("R2 latency one edge", d, 32'hFF00_0000);
    @(negedge clk);
    csr_rd(2'd2, d); chk("R2 cleared", d, 32'h0);

    // R7 trap and R8 return
    @(negedge clk); irq = 8'b0010_1000;
    csr_wr(2'd1, 32'hFF00_0000);
    repeat (3) @(negedge clk);
    chk("R4 req before trap", 32'(req), 1);
    chk("R6 cause line3", cause, 32'h8000_0013);
    trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0;
    csr_rd(2'd3, d); chk("R7 cause recorded", d, 32'h8000_0013);
    csr_rd(2'd0, d); chk("R7 status saved", d, 32'h8);
    @(negedge clk);
    chk("R7 req dropped", 32'(req), 0);
    mret = 1'b1;
    @(negedge clk); mret = 1'b0;
    csr_rd(2'd0, d); chk("R8 status restored", d, 32'h9);
    @(negedge clk);
    chk("R8 req back", 32'(req), 1);
    // R7 trap beats a concurrent status write
    @(negedge clk); sel = 2'd0; wdata = 32'h1; we = 1'b1; trap_ack = 1'b1;
    @(negedge clk); we = 1'b0; trap_ack = 1'b0;
    csr_rd(2'd0, d); chk("R7 priority over write", d, 32'h8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule